// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Unit

This block turns a bank of already-synchronized GPIO input pins into interrupt requests. Each pin is configured on its own. It can trigger on a level, high or low. It can trigger on an edge, rising or falling, or on both edges. Edge events are held in a latched status bit until software acknowledges them. Level conditions are not stored: the status bit shows the pin's live state. A per-pin enable gates the raw status into a masked status, and one interrupt line is raised whenever any masked bit is set.

The unit sits behind the port register block of a GPIO controller. That block supplies single-cycle, byte-wide write and read strobes with a 3-bit register index. Read data is combinational and qualified by the read strobe. No data stream passes through the unit, so every pin is a plain control or status signal and there is no valid/ready handshake. Writes take effect at the next rising clock edge.

Top module: `gis_irq_sense`

## Requirements
- R1: While reset is asserted and right after it, every configuration register and every status bit reads zero, and `irq_o` is low.
- R2: Register index 0 selects sense type, 1 selects both-edge, 2 selects polarity and 3 selects enable. Each of these reads back the value last written. Index 6 (clear) and index 7 read as zero.
- R3: A pin in edge mode (sense bit 0) with polarity bit 1 sets its raw status bit (index 4) on a 0-to-1 change of the pin. The bit is visible in the cycle after the clock edge that first sees the new pin value.
- R4: With polarity bit 0 the pin latches on a 1-to-0 change instead. A change in the opposite direction sets nothing. A latched bit stays set after the pin returns to its earlier value.
- R5: Writing index 6 clears each latched edge bit whose data bit is 1. Data bits of 0 leave their status bits unchanged.
- R6: When a pin's both-edge bit is 1 in edge mode, either direction of change latches its status bit, whatever its polarity bit holds.
- R7: With sense bit 1, the raw bit equals the pin when polarity is 1 and its inverse when polarity is 0. It follows the pin in the same cycle, drops without any clear, and is unaffected by writes to index 6.
- R8: Masked status (index 5) equals raw status AND enable. `irq_o` is high exactly when masked status is non-zero.
- R9: If an edge event and a clear write for the same bit meet at one clock edge, the bit ends up set.
- R10: A write to index 0, 1 or 2 that changes a pin's bit clears that pin's latched edge status. Rewriting the same value keeps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_PINS | Synchronized pin values |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 3 | Register index of the write |
| wr_data | input | N_PINS | Write data, one bit per pin |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register index of the read |
| rd_data | output | N_PINS | Read data, zero when rd_en is low |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check four things. The interrupt agrees with any masked-status read. A latched edge bit never drops without a register write. A clear write with a still pin really removes the cleared bits. No pin in level mode ever holds a latched bit. Only the bench scenarios can show the rest: which edge direction latches under each polarity and both-edge setting, that level status follows and releases with the pin, that an event beats a simultaneous clear, and that only a real configuration change discards a stale event.

// File: rtl/gis_pkg.sv
package gis_pkg;
  localparam int unsigned GIS_AW = 3;

  typedef enum logic [GIS_AW-1:0] {
    GIS_SENSE = 3'd0,
    GIS_BOTH  = 3'd1,
    GIS_POL   = 3'd2,
    GIS_EN    = 3'd3,
    GIS_RAW   = 3'd4,
    GIS_MASK  = 3'd5,
    GIS_CLR   = 3'd6,
    GIS_RSVD  = 3'd7
  } gis_reg_e;
endpackage

// File: rtl/gis_cfg_regs.sv
module gis_cfg_regs
  import gis_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GIS_AW-1:0] wr_addr,
  input  logic [N_PINS-1:0] wr_data,
  output logic [N_PINS-1:0] sense_o,
  output logic [N_PINS-1:0] both_o,
  output logic [N_PINS-1:0] pol_o,
  output logic [N_PINS-1:0] en_o,
  output logic [N_PINS-1:0] cfg_chg_o,
  output logic [N_PINS-1:0] clr_o
);
  logic [N_PINS-1:0] sense_q, both_q, pol_q, en_q;
  logic wr_sense, wr_both, wr_pol, wr_en_reg, wr_clr;

  always_comb begin
    wr_sense  = wr_en && (wr_addr == GIS_SENSE);
    wr_both   = wr_en && (wr_addr == GIS_BOTH);
    wr_pol    = wr_en && (wr_addr == GIS_POL);
    wr_en_reg = wr_en && (wr_addr == GIS_EN);
    wr_clr    = wr_en && (wr_addr == GIS_CLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else begin
      if (wr_sense)  sense_q <= wr_data;
      if (wr_both)   both_q  <= wr_data;
      if (wr_pol)    pol_q   <= wr_data;
      if (wr_en_reg) en_q    <= wr_data;
    end
  end

  // Bits whose detection setup changes at this edge.
  always_comb begin
    cfg_chg_o = '0;
    if (wr_sense) cfg_chg_o = wr_data ^ sense_q;
    if (wr_both)  cfg_chg_o = wr_data ^ both_q;
    if (wr_pol)   cfg_chg_o = wr_data ^ pol_q;
    clr_o = wr_clr ? wr_data : '0;
  end

  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;
  assign en_o    = en_q;
endmodule

// File: rtl/gis_pin_detect.sv
module gis_pin_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic sense,
  input  logic both,
  input  logic pol,
  input  logic cfg_chg,
  input  logic clr,
  output logic lat_o,
  output logic raw_o
);
  logic prev_q, lat_q;
  logic rise, fall, hit, level_act;

  always_comb begin
    rise      = pin & ~prev_q;
    fall      = ~pin & prev_q;
    hit       = ~sense & (both ? (rise | fall) : (pol ? rise : fall));
    level_act = pol ? pin : ~pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= pin;
      if (cfg_chg)  lat_q <= 1'b0;
      else if (hit) lat_q <= 1'b1;
      else if (clr) lat_q <= 1'b0;
    end
  end

  assign lat_o = lat_q;
  assign raw_o = sense ? level_act : lat_q;
endmodule

// File: rtl/gis_status.sv
module gis_status
  import gis_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              rd_en,
  input  logic [GIS_AW-1:0] rd_addr,
  input  logic [N_PINS-1:0] raw,
  input  logic [N_PINS-1:0] sense,
  input  logic [N_PINS-1:0] both,
  input  logic [N_PINS-1:0] pol,
  input  logic [N_PINS-1:0] en,
  output logic [N_PINS-1:0] rd_data,
  output logic              irq_o
);
  logic [N_PINS-1:0] masked;

  always_comb begin
    masked  = raw & en;
    irq_o   = |masked;
    rd_data = '0;
    if (rd_en) begin
      case (gis_reg_e'(rd_addr))
        GIS_SENSE: rd_data = sense;
        GIS_BOTH:  rd_data = both;
        GIS_POL:   rd_data = pol;
        GIS_EN:    rd_data = en;
        GIS_RAW:   rd_data = raw;
        GIS_MASK:  rd_data = masked;
        default:   rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/gis_irq_sense.sv
module gis_irq_sense
  import gis_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              wr_en,
  input  logic [GIS_AW-1:0] wr_addr,
  input  logic [N_PINS-1:0] wr_data,
  input  logic              rd_en,
  input  logic [GIS_AW-1:0] rd_addr,
  output logic [N_PINS-1:0] rd_data,
  output logic              irq_o
);
  logic [N_PINS-1:0] sense_w, both_w, pol_w, en_w, chg_w, clr_w;
  logic [N_PINS-1:0] lat_w, raw_w;

  gis_cfg_regs #(.N_PINS(N_PINS)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sense_o(sense_w), .both_o(both_w), .pol_o(pol_w), .en_o(en_w),
    .cfg_chg_o(chg_w), .clr_o(clr_w)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    gis_pin_detect det_i (
      .clk(clk), .rst_n(rst_n),
      .pin(pin_i[g]), .sense(sense_w[g]), .both(both_w[g]), .pol(pol_w[g]),
      .cfg_chg(chg_w[g]), .clr(clr_w[g]),
      .lat_o(lat_w[g]), .raw_o(raw_w[g])
    );
  end

  gis_status #(.N_PINS(N_PINS)) stat_i (
    .rd_en(rd_en), .rd_addr(rd_addr), .raw(raw_w),
    .sense(sense_w), .both(both_w), .pol(pol_w), .en(en_w),
    .rd_data(rd_data), .irq_o(irq_o)
  );
endmodule

// File: rtl/gis_irq_sense_chk.sv
module gis_irq_sense_chk
  import gis_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_PINS-1:0] pin_i,
  input logic              wr_en,
  input logic [GIS_AW-1:0] wr_addr,
  input logic [N_PINS-1:0] wr_data,
  input logic              rd_en,
  input logic [GIS_AW-1:0] rd_addr,
  input logic [N_PINS-1:0] rd_data,
  input logic              irq_o,
  input logic [N_PINS-1:0] lat_q,
  input logic [N_PINS-1:0] sense_q
);
  // R1: no request while held in reset
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !irq_o);

  // R8: a masked-status read agrees with the request line
  assert_irq_matches_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == GIS_MASK) |-> (irq_o == (rd_data != '0)));

  // R4: without any write, latched edge bits never drop
  assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

  // R5: clear write with a still pin removes the cleared bits
  assert_clear_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == GIS_CLR && $stable(pin_i)) |=> ((lat_q & $past(wr_data)) == '0));

  // R7: a level-sensed pin never carries a latched bit
  assert_level_unlatched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q & sense_q) == '0);
endmodule

bind gis_irq_sense gis_irq_sense_chk #(.N_PINS(N_PINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o),
  .lat_q(lat_w), .sense_q(sense_w)
);

// File: tb/gis_irq_sense_tb_top.sv
module gis_irq_sense_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  localparam logic [2:0] A_SENSE = 3'd0, A_BOTH = 3'd1, A_POL = 3'd2, A_EN = 3'd3,
                         A_RAW = 3'd4, A_MASK = 3'd5, A_CLR = 3'd6, A_RSVD = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_i = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [N-1:0] rd_data;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]   addr;
    logic [N-1:0] data;
    logic         irq;
    string        tag;
  } exp_t;
  exp_t exp_q[$];

  gis_irq_sense #(.N_PINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Driver tasks: all stimulus changes at the falling edge.
  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    pin_i = v;
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pins_and_write(input logic [N-1:0] v, input logic [2:0] a,
                                input logic [N-1:0] d);
    @(negedge clk);
    pin_i = v; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [N-1:0] d,
                           input logic irq, input string tag);
    exp_t it;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    it.addr = a; it.data = d; it.irq = irq; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Monitor: samples a quarter period after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rd_en && exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (rd_data !== it.data) begin
          errors++;
          $display("FAIL %s: index %0d data actual %h expected %h", it.tag, it.addr, rd_data, it.data);
        end
        checks++;
        if (irq_o !== it.irq) begin
          errors++;
          $display("FAIL %s: index %0d irq actual %b expected %b", it.tag, it.addr, irq_o, it.irq);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state, checked while still in reset then after release
    expect_rd(A_RAW, 8'h00, 1'b0, "R1 raw in reset");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) expect_rd(3'(i), 8'h00, 1'b0, "R1 reset value");

    // R2: readback
    write_reg(A_POL, 8'h01);
    write_reg(A_EN, 8'h01);
    expect_rd(A_POL, 8'h01, 1'b0, "R2 polarity readback");
    expect_rd(A_EN, 8'h01, 1'b0, "R2 enable readback");

    // R3: rising edge on pin0
    set_pins(8'h01);
    expect_rd(A_RAW, 8'h01, 1'b1, "R3 rising latched");
    expect_rd(A_MASK, 8'h01, 1'b1, "R3/R8 masked");
    // R4: opposite edge ignored, latch holds
    set_pins(8'h00);
    expect_rd(A_RAW, 8'h01, 1'b1, "R4 latch holds");
    // R5: zero bits of clear have no effect, ones clear
    write_reg(A_CLR, 8'hFE);
    expect_rd(A_RAW, 8'h01, 1'b1, "R5 zero bits ignored");
    write_reg(A_CLR, 8'h01);
    expect_rd(A_RAW, 8'h00, 1'b0, "R5 clear");

    // R4: falling edge on pin1 (polarity 0), rising ignored
    set_pins(8'h02);
    expect_rd(A_RAW, 8'h00, 1'b0, "R4 rising ignored");
    set_pins(8'h00);
    expect_rd(A_RAW, 8'h02, 1'b0, "R4 falling latched");
    expect_rd(A_MASK, 8'h00, 1'b0, "R8 disabled pin masked");
    write_reg(A_EN, 8'h03);
    expect_rd(A_MASK, 8'h02, 1'b1, "R8 enabled pin");
    write_reg(A_CLR, 8'h02);
    expect_rd(A_RAW, 8'h00, 1'b0, "R5 clear pin1");

    // R6: both edges on pin2
    write_reg(A_BOTH, 8'h04);
    expect_rd(A_BOTH, 8'h04, 1'b0, "R2 both readback");
    set_pins(8'h04);
    expect_rd(A_RAW, 8'h04, 1'b0, "R6 rise with polarity 0");
    write_reg(A_CLR, 8'h04);
    set_pins(8'h00);
    expect_rd(A_RAW, 8'h04, 1'b0, "R6 fall");
    write_reg(A_POL, 8'h05);
    expect_rd(A_RAW, 8'h00, 1'b0, "R10 config change clears");
    set_pins(8'h04);
    expect_rd(A_RAW, 8'h04, 1'b0, "R6 rise with polarity 1");
    write_reg(A_CLR, 8'h04);
    set_pins(8'h00);
    expect_rd(A_RAW, 8'h04, 1'b0, "R6 fall with polarity 1");
    write_reg(A_CLR, 8'h04);
    expect_rd(A_RAW, 8'h00, 1'b0, "R5 clear pin2");

    // R7: level high on pin3
    write_reg(A_SENSE, 8'h08);
    write_reg(A_POL, 8'h0D);
    expect_rd(A_RAW, 8'h00, 1'b0, "R7 level inactive");
    set_pins(8'h08);
    expect_rd(A_RAW, 8'h08, 1'b0, "R7 level high active");
    write_reg(A_CLR, 8'h08);
    expect_rd(A_RAW, 8'h08, 1'b0, "R7 clear ignored for level");
    set_pins(8'h00);
    expect_rd(A_RAW, 8'h00, 1'b0, "R7 level drops by itself");

    // R7: level low on pin4
    write_reg(A_SENSE, 8'h18);
    expect_rd(A_RAW, 8'h10, 1'b0, "R7 level low active");
    write_reg(A_EN, 8'h13);
    expect_rd(A_MASK, 8'h10, 1'b1, "R8 level masked");
    set_pins(8'h10);
    expect_rd(A_RAW, 8'h00, 1'b0, "R7 level low released");

    // R9: event and clear at the same edge
    pins_and_write(8'h11, A_CLR, 8'h01);
    expect_rd(A_RAW, 8'h01, 1'b1, "R9 event wins");
    write_reg(A_CLR, 8'h01);
    expect_rd(A_RAW, 8'h00, 1'b0, "R5 clear after race");

    // R10: unchanged rewrite keeps, changed bit clears
    set_pins(8'h10);
    expect_rd(A_RAW, 8'h00, 1'b0, "R4 falling ignored at polarity 1");
    set_pins(8'h11);
    expect_rd(A_RAW, 8'h01, 1'b1, "R3 rising again");
    write_reg(A_POL, 8'h0D);
    expect_rd(A_RAW, 8'h01, 1'b1, "R10 same value keeps");
    write_reg(A_POL, 8'h0C);
    expect_rd(A_RAW, 8'h00, 1'b0, "R10 changed bit clears");

    expect_rd(A_CLR, 8'h00, 1'b0, "R2 clear index reads zero");
    expect_rd(A_RSVD, 8'h00, 1'b0, "R2 spare index reads zero");
    expect_rd(A_SENSE, 8'h18, 1'b0, "R2 sense readback");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule